// File: doc/BRIEF.md
# Composite Vertical Blanking and FIFO-Reset Generator

This block follows the raster position of a composite digital video stream, one word per sample-enable, and produces two registered outputs. The first is a vertical-blanking flag. It is high over two windows per frame. Each window opens and closes at a particular sample inside a line, not at a line boundary. The window positions depend on the selected standard (525-line or 625-line composite) and on a short/long blanking select.

The second output is an active-low reset for a downstream line-store FIFO. It drops for exactly one word when the timing-reference ID word passes through. In component mode, a select input decides whether that word is the end-of-active-video (EAV) or start-of-active-video (SAV) reference. In composite mode every line has a single reference ID word, so the select is ignored.

An upstream reference decoder keeps the position counters aligned by loading a line/sample pair through an alignment strobe. Between loads the counters free-run.

Top module: `comp_vblank_fifo_gen`

## Requirements
- R1: While `rst_n` is low, `vblank_o` is 0 and `fifo_rst_n` is 1, and the position counter sits at line 1, sample 0.
- R2: Each cycle with `samp_en_i` high and `align_i` low moves the position to the next sample. With `std_pal_i`=0 a line has samples 0..909 and a frame has lines 1..525. With `std_pal_i`=1 a line has samples 0..1134 and a frame has lines 1..625. After the last sample the count returns to sample 0 of the next line, and after the last line it returns to line 1.
- R3: A cycle with `align_i` high loads `align_line_i`/`align_samp_i` as the current position. In that cycle the sample enable, the outputs and the strobe are ignored.
- R4: The outputs change only on the clock edge that ends an enabled, non-align cycle. They then describe the word consumed in that cycle. In all other cycles they hold their values.
- R5: With `std_pal_i`=0 and `blank_long_i`=0, the flag is 1 for positions from (525,768) through (9,767) across the frame wrap, and from (263,313) through (272,767). Both ranges are inclusive.
- R6: With `std_pal_i`=0 and `blank_long_i`=1, the start points are the same as in R5, but the ranges end at (19,767) and (282,767).
- R7: With `std_pal_i`=1 and `blank_long_i`=0, the flag is 1 from (623,382) through (5,947), and from (310,948) through (317,947).
- R8: With `std_pal_i`=1 and `blank_long_i`=1, the ranges of R7 end at (15,947) and (327,947).
- R9: With `comp_mode_i`=0, an enabled word with `trs_id_i`=1 drives `fifo_rst_n` low for that word, whatever the values of `eav_sel_i` and `trs_is_eav_i`.
- R10: With `comp_mode_i`=1, an enabled word with `trs_id_i`=1 drives `fifo_rst_n` low only when `trs_is_eav_i` equals `eav_sel_i` (1 = EAV, 0 = SAV). Otherwise it stays high.
- R11: Every enabled word with `trs_id_i`=0 leaves `fifo_rst_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en_i | input | 1 | One video word is consumed this cycle |
| std_pal_i | input | 1 | 0 = 525-line standard, 1 = 625-line standard |
| blank_long_i | input | 1 | 0 = short blanking windows, 1 = long |
| comp_mode_i | input | 1 | 0 = composite, 1 = component |
| eav_sel_i | input | 1 | Component reset position: 1 = EAV, 0 = SAV |
| trs_id_i | input | 1 | Current word is a timing-reference ID word |
| trs_is_eav_i | input | 1 | Current reference word is an EAV (component mode) |
| align_i | input | 1 | Load the position counter |
| align_line_i | input | 10 | Line number to load (1-based) |
| align_samp_i | input | 11 | Sample number to load |
| vblank_o | output | 1 | Vertical-blanking flag for the last consumed word |
| fifo_rst_n | output | 1 | Active-low FIFO reset for the last consumed word |

## Verification
Both outputs come from a single register stage. The result for a word consumed in an enabled cycle is therefore due one clock edge later, and it stays until the next enabled cycle. After an alignment load, the first enabled word reports the loaded position. The bench drives each word half a period before the edge and samples at the following falling edge. At that moment it compares against a reference that replays the position and the windows from the requirements alone. Stall cycles are checked for a held value, and starting points are loaded just ahead of every window edge and frame wrap so the boundary samples are hit directly.

// File: rtl/cvb_pkg.sv
package cvb_pkg;
  localparam int LINE_W = 10;
  localparam int SAMP_W = 11;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [SAMP_W-1:0] samp_t;

  // Raster extents per standard
  localparam line_t NTSC_LAST_LINE = line_t'(525);
  localparam samp_t NTSC_LAST_SAMP = samp_t'(909);
  localparam line_t PAL_LAST_LINE  = line_t'(625);
  localparam samp_t PAL_LAST_SAMP  = samp_t'(1134);

  typedef struct packed {
    line_t beg_line;
    samp_t beg_samp;
    line_t end_line;
    samp_t end_samp;
  } span_t;

  // lexicographic position comparisons
  function automatic logic pos_ge(line_t l, samp_t s, line_t rl, samp_t rs);
    return (l > rl) || ((l == rl) && (s >= rs));
  endfunction

  function automatic logic pos_le(line_t l, samp_t s, line_t rl, samp_t rs);
    return (l < rl) || ((l == rl) && (s <= rs));
  endfunction
endpackage

// File: rtl/cvb_pos_counter.sv
module cvb_pos_counter
  import cvb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  logic  load_i,
  input  line_t load_line_i,
  input  samp_t load_samp_i,
  input  logic  pal_i,
  output line_t line_o,
  output samp_t samp_o
);
  line_t line_q, line_d;
  samp_t samp_q, samp_d;
  line_t last_line;
  samp_t last_samp;

  always_comb begin
    last_line = pal_i ? PAL_LAST_LINE : NTSC_LAST_LINE;
    last_samp = pal_i ? PAL_LAST_SAMP : NTSC_LAST_SAMP;
    line_d    = line_q;
    samp_d    = samp_q;
    if (load_i) begin
      line_d = load_line_i;
      samp_d = load_samp_i;
    end else if (adv_i) begin
      if (samp_q >= last_samp) begin
        samp_d = '0;
        line_d = (line_q >= last_line) ? line_t'(1) : line_q + line_t'(1);
      end else begin
        samp_d = samp_q + samp_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= line_t'(1);
      samp_q <= '0;
    end else if (load_i || adv_i) begin
      line_q <= line_d;
      samp_q <= samp_d;
    end
  end

  assign line_o = line_q;
  assign samp_o = samp_q;
endmodule

// File: rtl/cvb_blank_window.sv
module cvb_blank_window
  import cvb_pkg::*;
(
  input  line_t line_i,
  input  samp_t samp_i,
  input  logic  pal_i,
  input  logic  long_i,
  output logic  blank_o
);
  span_t wrap_span;
  span_t mid_span;
  logic  in_wrap;
  logic  in_mid;

  always_comb begin
    unique case ({pal_i, long_i})
      2'b00: begin
        wrap_span = '{line_t'(525), samp_t'(768), line_t'(9),   samp_t'(767)};
        mid_span  = '{line_t'(263), samp_t'(313), line_t'(272), samp_t'(767)};
      end
      2'b01: begin
        wrap_span = '{line_t'(525), samp_t'(768), line_t'(19),  samp_t'(767)};
        mid_span  = '{line_t'(263), samp_t'(313), line_t'(282), samp_t'(767)};
      end
      2'b10: begin
        wrap_span = '{line_t'(623), samp_t'(382), line_t'(5),   samp_t'(947)};
        mid_span  = '{line_t'(310), samp_t'(948), line_t'(317), samp_t'(947)};
      end
      default: begin
        wrap_span = '{line_t'(623), samp_t'(382), line_t'(15),  samp_t'(947)};
        mid_span  = '{line_t'(310), samp_t'(948), line_t'(327), samp_t'(947)};
      end
    endcase
  end

  // wrap span: union of the tail before frame end and the head after it
  assign in_wrap = pos_ge(line_i, samp_i, wrap_span.beg_line, wrap_span.beg_samp) ||
                   pos_le(line_i, samp_i, wrap_span.end_line, wrap_span.end_samp);
  assign in_mid  = pos_ge(line_i, samp_i, mid_span.beg_line, mid_span.beg_samp) &&
                   pos_le(line_i, samp_i, mid_span.end_line, mid_span.end_samp);
  assign blank_o = in_wrap || in_mid;
endmodule

// File: rtl/cvb_fifo_pulse.sv
module cvb_fifo_pulse (
  input  logic trs_id_i,
  input  logic comp_mode_i,
  input  logic trs_is_eav_i,
  input  logic eav_sel_i,
  output logic fire_o
);
  logic kind_match;
  assign kind_match = (trs_is_eav_i == eav_sel_i);
  assign fire_o     = trs_id_i && (!comp_mode_i || kind_match);
endmodule

// File: rtl/comp_vblank_fifo_gen.sv
module comp_vblank_fifo_gen
  import cvb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en_i,
  input  logic              std_pal_i,
  input  logic              blank_long_i,
  input  logic              comp_mode_i,
  input  logic              eav_sel_i,
  input  logic              trs_id_i,
  input  logic              trs_is_eav_i,
  input  logic              align_i,
  input  logic [LINE_W-1:0] align_line_i,
  input  logic [SAMP_W-1:0] align_samp_i,
  output logic              vblank_o,
  output logic              fifo_rst_n
);
  line_t cur_line;
  samp_t cur_samp;
  logic  word_en;
  logic  blank_now;
  logic  fire_now;
  logic  vblank_q, vblank_d;
  logic  frst_q, frst_d;

  assign word_en = samp_en_i && !align_i;

  cvb_pos_counter u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (word_en),
    .load_i     (align_i),
    .load_line_i(align_line_i),
    .load_samp_i(align_samp_i),
    .pal_i      (std_pal_i),
    .line_o     (cur_line),
    .samp_o     (cur_samp)
  );

  cvb_blank_window u_win (
    .line_i (cur_line),
    .samp_i (cur_samp),
    .pal_i  (std_pal_i),
    .long_i (blank_long_i),
    .blank_o(blank_now)
  );

  cvb_fifo_pulse u_pulse (
    .trs_id_i    (trs_id_i),
    .comp_mode_i (comp_mode_i),
    .trs_is_eav_i(trs_is_eav_i),
    .eav_sel_i   (eav_sel_i),
    .fire_o      (fire_now)
  );

  always_comb begin
    vblank_d = blank_now;
    frst_d   = !fire_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vblank_q <= 1'b0;
      frst_q   <= 1'b1;
    end else if (word_en) begin
      vblank_q <= vblank_d;
      frst_q   <= frst_d;
    end
  end

  assign vblank_o   = vblank_q;
  assign fifo_rst_n = frst_q;
endmodule

// File: rtl/cvb_checker.sv
module cvb_checker
  import cvb_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  samp_en_i,
  input logic  std_pal_i,
  input logic  comp_mode_i,
  input logic  eav_sel_i,
  input logic  trs_id_i,
  input logic  trs_is_eav_i,
  input logic  align_i,
  input line_t cur_line,
  input samp_t cur_samp,
  input logic  vblank_o,
  input logic  fifo_rst_n
);
  p_line_range_r2: assert property (@(posedge clk) disable iff (!rst_n || align_i)
    samp_en_i |=> (cur_line >= line_t'(1)) && (cur_line <= PAL_LAST_LINE));

  p_samp_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en_i && !align_i && !std_pal_i && cur_samp == NTSC_LAST_SAMP
    |=> cur_samp == samp_t'(0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_en_i || align_i) |=> $stable(vblank_o) && $stable(fifo_rst_n));

  p_line1_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en_i && !align_i && cur_line == line_t'(1) |=> vblank_o);

  p_line100_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en_i && !align_i && cur_line == line_t'(100) |=> !vblank_o);

  p_comp_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en_i && !align_i && trs_id_i && !comp_mode_i |=> !fifo_rst_n);

  p_kind_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en_i && !align_i && trs_id_i && comp_mode_i && (trs_is_eav_i != eav_sel_i)
    |=> fifo_rst_n);

  p_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en_i && !align_i && !trs_id_i |=> fifo_rst_n);
endmodule

bind comp_vblank_fifo_gen cvb_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .samp_en_i   (samp_en_i),
  .std_pal_i   (std_pal_i),
  .comp_mode_i (comp_mode_i),
  .eav_sel_i   (eav_sel_i),
  .trs_id_i    (trs_id_i),
  .trs_is_eav_i(trs_is_eav_i),
  .align_i     (align_i),
  .cur_line    (cur_line),
  .cur_samp    (cur_samp),
  .vblank_o    (vblank_o),
  .fifo_rst_n  (fifo_rst_n)
);

// File: tb/comp_vblank_fifo_gen_tb.sv
module comp_vblank_fifo_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_en = 1'b0, std_pal = 1'b0, blank_long = 1'b0, comp_mode = 1'b0;
  logic        eav_sel = 1'b0, trs_id = 1'b0, trs_eav = 1'b0, align = 1'b0;
  logic [9:0]  al_line = 10'd1;
  logic [10:0] al_samp = 11'd0;
  logic        vblank, frst_n;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int  m_line, m_samp;
  bit  e_vb, e_fr;

  always #4 clk = ~clk;

  comp_vblank_fifo_gen u_dut (
    .clk(clk), .rst_n(rst_n), .samp_en_i(samp_en), .std_pal_i(std_pal),
    .blank_long_i(blank_long), .comp_mode_i(comp_mode), .eav_sel_i(eav_sel),
    .trs_id_i(trs_id), .trs_is_eav_i(trs_eav), .align_i(align),
    .align_line_i(al_line), .align_samp_i(al_samp),
    .vblank_o(vblank), .fifo_rst_n(frst_n)
  );

  function automatic bit ge(int l, int s, int rl, int rs);
    return (l > rl) || (l == rl && s >= rs);
  endfunction
  function automatic bit le(int l, int s, int rl, int rs);
    return (l < rl) || (l == rl && s <= rs);
  endfunction

  function automatic bit exp_blank(bit pal, bit lng, int l, int s);
    int a_l, a_s, b_l, b_s, c_l, c_s, d_l, d_s;
    if (!pal) begin
      a_l = 525; a_s = 768; b_l = lng ? 19 : 9;  b_s = 767;
      c_l = 263; c_s = 313; d_l = lng ? 282 : 272; d_s = 767;
    end else begin
      a_l = 623; a_s = 382; b_l = lng ? 15 : 5;  b_s = 947;
      c_l = 310; c_s = 948; d_l = lng ? 327 : 317; d_s = 947;
    end
    return ge(l, s, a_l, a_s) || le(l, s, b_l, b_s) ||
           (ge(l, s, c_l, c_s) && le(l, s, d_l, d_s));
  endfunction

  function automatic string win_tag(bit pal, bit lng);
    if (!pal) return lng ? "R6" : "R5";
    return lng ? "R8" : "R7";
  endfunction

  task automatic check(string tag, string what, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b line=%0d samp=%0d",
               tag, what, act, exp, m_line, m_samp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; samp_en = 0; align = 0; trs_id = 0;
    repeat (2) @(negedge clk);
    m_line = 1; m_samp = 0; e_vb = 0; e_fr = 1;
    check("R1", "vblank", vblank, 1'b0);
    check("R1", "fifo_rst_n", frst_n, 1'b1);
    rst_n = 1'b1;
  endtask

  // drive one cycle at the falling edge, update model at the rising edge,
  // compare at the next falling edge
  task automatic step(bit en, bit al, int al_l, int al_s, bit strb, bit kind, string tag);
    string vt, ft;
    samp_en = en; align = al; al_line = al_l[9:0]; al_samp = al_s[10:0];
    trs_id = strb; trs_eav = kind;
    @(posedge clk);
    if (al) begin
      m_line = al_l; m_samp = al_s;
    end else if (en) begin
      e_vb = exp_blank(std_pal, blank_long, m_line, m_samp);
      e_fr = !(strb && (!comp_mode || kind == eav_sel));
      if (m_samp >= (std_pal ? 1134 : 909)) begin
        m_samp = 0;
        m_line = (m_line >= (std_pal ? 625 : 525)) ? 1 : m_line + 1;
      end else m_samp++;
    end
    @(negedge clk);
    vt = (tag != "") ? tag : win_tag(std_pal, blank_long);
    ft = (tag != "") ? tag : (!strb ? "R11" : (comp_mode ? "R10" : "R9"));
    check(vt, "vblank", vblank, e_vb);
    check(ft, "fifo_rst_n", frst_n, e_fr);
  endtask

  int nt_l[8] = '{525, 9, 19, 263, 272, 282, 524, 525};
  int nt_s[8] = '{765, 765, 765, 310, 765, 765, 905, 900};
  int pl_l[8] = '{623, 5, 15, 310, 317, 327, 625, 624};
  int pl_s[8] = '{379, 944, 944, 945, 944, 944, 1130, 1130};

  initial begin
    do_reset();

    // R2: sample wrap after 909 and line wrap after 525 (NTSC)
    std_pal = 0; blank_long = 1; comp_mode = 0;
    step(0, 1, 525, 905, 0, 0, "R3");
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0, "R2");
    // R2: 625-line wrap
    std_pal = 1;
    step(0, 1, 625, 1132, 0, 0, "R3");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 0, "R2");
    // R3: align ignores enable and strobe in the same cycle
    std_pal = 0; blank_long = 0;
    step(1, 1, 525, 766, 1, 0, "R3");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, "R3");
    // R4: stall cycles keep outputs
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0, "R4");
    // R9: composite ignores eav select
    comp_mode = 0; eav_sel = 1;
    step(1, 0, 0, 0, 1, 0, "R9");
    step(1, 0, 0, 0, 0, 0, "R11");
    // R10: component steering
    comp_mode = 1; eav_sel = 0;
    step(1, 0, 0, 0, 1, 1, "R10");
    step(1, 0, 0, 0, 1, 0, "R10");
    eav_sel = 1;
    step(1, 0, 0, 0, 1, 1, "R10");
    step(1, 0, 0, 0, 1, 0, "R10");

    // random segments near window edges
    void'($urandom(32'h5eed_0c21));
    for (int seg = 0; seg < 48; seg++) begin
      int k;
      std_pal = $urandom_range(0, 1);
      if (seg % 8 == 0) do_reset();
      blank_long = $urandom_range(0, 1);
      comp_mode  = $urandom_range(0, 1);
      eav_sel    = $urandom_range(0, 1);
      k = $urandom_range(0, 7);
      if (std_pal) step(0, 1, pl_l[k], pl_s[k], 0, 0, "R3");
      else         step(0, 1, nt_l[k], nt_s[k], 0, 0, "R3");
      for (int i = 0; i < 400; i++) begin
        if ($urandom_range(0, 99) < 2) blank_long = ~blank_long;
        step($urandom_range(0, 3) != 0, 0, 0, 0,
             $urandom_range(0, 9) == 0, $urandom_range(0, 1), "");
      end
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule